// File: doc/BRIEF.md
# Teletext Page Memory Row Writer

This block sits between a teletext acquisition front end and a 40-column by 26-row character memory. Each decoded byte arrives with its packet row number, column and a write strobe. The block turns that into at most one memory write per clock. The address is row times 40 plus column. Whether the byte is written at all depends on which row and column it belongs to, on whether the decoder is still hunting for the requested page, and on a control bit that lets row 24 be filled from packet 24.

The block treats the header row (row 0) in four parts:
- Columns 0 to 6 belong to software status text. Acquisition never writes them.
- Column 7 holds a colour control character that only the block itself writes.
- Columns 8 to 31 take the received header text only while searching, so they roll while searching and freeze once the page is found.
- The last eight columns carry the time and are refreshed from every header.

Row 25 keeps received page control data in its first ten columns. Its remaining columns are left for software.

Whenever the searching flag changes, and once after reset, the block queues a rewrite of the colour control character. It writes alphanumeric green while searching and alphanumeric white otherwise. That rewrite waits for a clock in which no packet byte is being written.

Top module: `ttx_row_writer`

## Requirements
- R1: A byte presented with `pktValid` high at a clock edge appears on the write port (`memWe` high, `memAddr` = row*40+column, `memData` = byte) right after that edge. `memWe` is low after any edge that produced no write. After reset `memWe` is low.
- R2: Row 0 columns 0 to 6 are never written by packet bytes. Row 0 column 7 is never written with a packet byte.
- R3: Column 7 of row 0 (address 7) is written by the block with 0x02 if `searching` is 1 at the issuing edge, and with 0x07 if it is 0. One such write is queued by reset and one by every edge at which `searching` differs from its value at the previous edge; before the first edge after reset that previous value is taken as 1.
- R4: Row 0 columns 8 to 31 are written from packets only when `searching` is 1.
- R5: Row 0 columns 32 to 39 are written from every packet byte, whatever the value of `searching`.
- R6: Row 24 is written from packets only when `rowStoreEn` is 1.
- R7: Rows 1 to 23 are written at every column 0 to 39.
- R8: Row 25 columns 0 to 9 are written. Row 25 columns 10 to 39 are never written.
- R9: A packet byte with row above 25 or column above 39 produces no write.
- R10: When a packet write and a queued colour write compete for the same edge, the packet write is issued. The colour write follows at the first edge with no packet write. Several queued changes collapse into one write that uses the value current at issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pktValid | input | 1 | Strobe qualifying the byte on `pktByte` |
| pktRow | input | 5 | Packet row number (0 to 31) |
| pktCol | input | 6 | Column of the byte within the row |
| pktByte | input | 8 | Character data |
| searching | input | 1 | 1 while the requested page is still being looked for |
| rowStoreEn | input | 1 | Control bit enabling storage of packet 24 into row 24 |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 11 | Memory write address, row*40+column |
| memData | output | 8 | Memory write data |

## Verification
A packet byte is due on the write port one edge after it is presented. The bench drives inputs on the falling edge and samples two nanoseconds after the next rising edge, so each check lines up with exactly one edge. A colour rewrite is due one edge after the change of `searching` is seen, or later if packet writes hold it off. The bench therefore keeps its own pending flag and previous searching value, updated once per edge, and predicts for every edge whether a colour write, a packet write or nothing is due. Random packets over the whole row and column range, with random flag toggles, are mixed with directed runs at each region boundary and at collisions between packet writes and queued colour writes.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  // Strobes handed from control to datapath each clock.
  typedef struct packed {
    logic pktWr;     // write the incoming packet byte
    logic colWr;     // write the header colour control character
    logic colGreen;  // colour to use: 1 = green (searching), 0 = white
  } wrStrobe_t;

  localparam logic [7:0] ALPHA_WHITE = 8'h07;
  localparam logic [7:0] ALPHA_GREEN = 8'h02;
endpackage

// File: rtl/ttx_ctrl.sv
module ttx_ctrl
  import ttx_pkg::*;
#(
  parameter int COLS       = 40,
  parameter int ROWS       = 26,
  parameter int STATUS_W   = 7,
  parameter int ROLL_W     = 24,
  parameter int TIME_W     = 8,
  parameter int CTRL_BYTES = 10,
  parameter int EXTRA_ROW  = 24,
  parameter int ROW_IN_W   = 5,
  parameter int COL_IN_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pktValid,
  input  logic [ROW_IN_W-1:0] pktRow,
  input  logic [COL_IN_W-1:0] pktCol,
  input  logic                searching,
  input  logic                rowStoreEn,
  output wrStrobe_t           strobe
);
  localparam int ROLL_LO  = STATUS_W + 1;
  localparam int ROLL_HI  = ROLL_LO + ROLL_W - 1;
  localparam int TIME_LO  = COLS - TIME_W;
  localparam int CTRL_ROW = ROWS - 1;

  logic searchQ;
  logic colPending;
  logic inRange;
  logic regionOk;
  logic pktWr;
  logic colWr;

  always_comb begin
    inRange = (pktCol < COL_IN_W'(COLS)) && (pktRow < ROW_IN_W'(ROWS));
    if (pktRow == '0) begin
      if (pktCol >= COL_IN_W'(TIME_LO))
        regionOk = 1'b1;
      else if (pktCol >= COL_IN_W'(ROLL_LO) && pktCol <= COL_IN_W'(ROLL_HI))
        regionOk = searching;
      else
        regionOk = 1'b0;
    end else if (pktRow == ROW_IN_W'(EXTRA_ROW)) begin
      regionOk = rowStoreEn;
    end else if (pktRow == ROW_IN_W'(CTRL_ROW)) begin
      regionOk = pktCol < COL_IN_W'(CTRL_BYTES);
    end else begin
      regionOk = 1'b1;
    end
    pktWr = pktValid && inRange && regionOk;
    colWr = colPending && !pktWr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      searchQ    <= 1'b1;
      colPending <= 1'b1;
    end else begin
      searchQ    <= searching;
      colPending <= (searching != searchQ) || (colPending && !colWr);
    end
  end

  assign strobe = '{pktWr: pktWr, colWr: colWr, colGreen: searching};
endmodule

// File: rtl/ttx_dp.sv
module ttx_dp
  import ttx_pkg::*;
#(
  parameter int COLS     = 40,
  parameter int ROWS     = 26,
  parameter int STATUS_W = 7,
  parameter int ROW_IN_W = 5,
  parameter int COL_IN_W = 6,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = $clog2(COLS * ROWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wrStrobe_t           strobe,
  input  logic [ROW_IN_W-1:0] pktRow,
  input  logic [COL_IN_W-1:0] pktCol,
  input  logic [DATA_W-1:0]   pktByte,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memData
);
  localparam logic [ADDR_W-1:0] COLOUR_ADDR = ADDR_W'(STATUS_W);

  logic [ADDR_W-1:0] pktAddr;
  logic [DATA_W-1:0] colourCode;

  always_comb begin
    pktAddr    = ADDR_W'(pktRow) * ADDR_W'(COLS) + ADDR_W'(pktCol);
    colourCode = strobe.colGreen ? DATA_W'(ALPHA_GREEN) : DATA_W'(ALPHA_WHITE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWe <= strobe.pktWr || strobe.colWr;
      if (strobe.pktWr) begin
        memAddr <= pktAddr;
        memData <= pktByte;
      end else if (strobe.colWr) begin
        memAddr <= COLOUR_ADDR;
        memData <= colourCode;
      end
    end
  end
endmodule

// File: rtl/ttx_row_writer.sv
module ttx_row_writer
  import ttx_pkg::*;
#(
  parameter int COLS       = 40,
  parameter int ROWS       = 26,
  parameter int STATUS_W   = 7,
  parameter int ROLL_W     = 24,
  parameter int TIME_W     = 8,
  parameter int CTRL_BYTES = 10,
  parameter int EXTRA_ROW  = 24,
  parameter int ROW_IN_W   = 5,
  parameter int COL_IN_W   = 6,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = $clog2(COLS * ROWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pktValid,
  input  logic [ROW_IN_W-1:0] pktRow,
  input  logic [COL_IN_W-1:0] pktCol,
  input  logic [DATA_W-1:0]   pktByte,
  input  logic                searching,
  input  logic                rowStoreEn,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memData
);
  wrStrobe_t strobe;

  ttx_ctrl #(
    .COLS(COLS), .ROWS(ROWS), .STATUS_W(STATUS_W), .ROLL_W(ROLL_W),
    .TIME_W(TIME_W), .CTRL_BYTES(CTRL_BYTES), .EXTRA_ROW(EXTRA_ROW),
    .ROW_IN_W(ROW_IN_W), .COL_IN_W(COL_IN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pktValid(pktValid), .pktRow(pktRow),
    .pktCol(pktCol), .searching(searching), .rowStoreEn(rowStoreEn),
    .strobe(strobe)
  );

  ttx_dp #(
    .COLS(COLS), .ROWS(ROWS), .STATUS_W(STATUS_W), .ROW_IN_W(ROW_IN_W),
    .COL_IN_W(COL_IN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .pktRow(pktRow),
    .pktCol(pktCol), .pktByte(pktByte), .memWe(memWe), .memAddr(memAddr),
    .memData(memData)
  );
endmodule

// File: rtl/ttx_row_writer_chk.sv
module ttx_row_writer_chk #(
  parameter int COLS       = 40,
  parameter int ROWS       = 26,
  parameter int STATUS_W   = 7,
  parameter int ROLL_W     = 24,
  parameter int CTRL_BYTES = 10,
  parameter int EXTRA_ROW  = 24,
  parameter int ROW_IN_W   = 5,
  parameter int COL_IN_W   = 6,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pktValid,
  input logic [ROW_IN_W-1:0] pktRow,
  input logic [COL_IN_W-1:0] pktCol,
  input logic [DATA_W-1:0]   pktByte,
  input logic                searching,
  input logic                rowStoreEn,
  input logic                memWe,
  input logic [ADDR_W-1:0]   memAddr,
  input logic [DATA_W-1:0]   memData
);
  localparam int ROLL_LO  = STATUS_W + 1;
  localparam int ROLL_HI  = ROLL_LO + ROLL_W - 1;
  localparam int ROW24_LO = EXTRA_ROW * COLS;
  localparam int ROW25_LO = (ROWS - 1) * COLS;

  AST_STATUS_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> (int'(memAddr) >= STATUS_W)); // R2

  AST_COLOUR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe && int'(memAddr) == STATUS_W) |-> (memData == 8'h02 || memData == 8'h07)); // R3

  AST_ROLL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe && int'(memAddr) >= ROLL_LO && int'(memAddr) <= ROLL_HI) |-> $past(searching)); // R4

  AST_EXTRA_ROW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe && int'(memAddr) >= ROW24_LO && int'(memAddr) < ROW24_LO + COLS) |-> $past(rowStoreEn)); // R6

  AST_CTRL_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> !(int'(memAddr) >= ROW25_LO + CTRL_BYTES)); // R8

  AST_BODY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pktValid && pktRow >= ROW_IN_W'(1) && pktRow <= ROW_IN_W'(23) && pktCol < COL_IN_W'(COLS))
    |=> (memWe && int'(memAddr) == int'($past(pktRow)) * COLS + int'($past(pktCol))
         && memData == $past(pktByte))); // R7

  AST_RANGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (pktValid && pktRow >= ROW_IN_W'(ROWS)) |=> (!memWe || int'(memAddr) == STATUS_W)); // R9
endmodule

bind ttx_row_writer ttx_row_writer_chk #(
  .COLS(COLS), .ROWS(ROWS), .STATUS_W(STATUS_W), .ROLL_W(ROLL_W),
  .CTRL_BYTES(CTRL_BYTES), .EXTRA_ROW(EXTRA_ROW), .ROW_IN_W(ROW_IN_W),
  .COL_IN_W(COL_IN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pktValid(pktValid), .pktRow(pktRow),
  .pktCol(pktCol), .pktByte(pktByte), .searching(searching),
  .rowStoreEn(rowStoreEn), .memWe(memWe), .memAddr(memAddr), .memData(memData)
);

// File: tb/ttx_row_writer_test.sv
module ttx_row_writer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pktValid;
  logic [4:0]  pktRow;
  logic [5:0]  pktCol;
  logic [7:0]  pktByte;
  logic        searching;
  logic        rowStoreEn;
  logic        memWe;
  logic [10:0] memAddr;
  logic [7:0]  memData;

  int checks = 0;
  int errors = 0;
  bit mPend;
  bit mSearchQ;
  bit finished = 0;

  always #4 clk = ~clk;

  ttx_row_writer uut (
    .clk(clk), .rst_n(rst_n), .pktValid(pktValid), .pktRow(pktRow),
    .pktCol(pktCol), .pktByte(pktByte), .searching(searching),
    .rowStoreEn(rowStoreEn), .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  // Requirement-derived write decision for one packet byte.
  function automatic bit gateOk(int r, int c, bit s, bit e);
    if (r > 25 || c > 39) return 0;            // R9
    if (r == 0) begin
      if (c <= 7) return 0;                    // R2
      if (c <= 31) return s;                   // R4
      return 1;                                // R5
    end
    if (r == 24) return e;                     // R6
    if (r == 25) return c < 10;                // R8
    return 1;                                  // R7
  endfunction

  function automatic string reqOf(int r, int c);
    if (r > 25 || c > 39) return "R9";
    if (r == 0) return (c <= 7) ? "R2" : (c <= 31) ? "R4" : "R5";
    if (r == 24) return "R6";
    if (r == 25) return "R8";
    return "R7";
  endfunction

  task automatic check(string tag, bit okCond, string what, int act, int exp);
    checks++;
    if (!okCond) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock: present inputs, predict, sample after the edge, advance model.
  task automatic step(bit v, int r, int c, logic [7:0] b, bit s, bit e, string tag = "");
    bit pw, cw;
    bit expWe;
    int expA;
    int expD;
    string t;
    pktValid = v; pktRow = 5'(r); pktCol = 6'(c); pktByte = b;
    searching = s; rowStoreEn = e;
    pw = v && gateOk(r, c, s, e);
    cw = mPend && !pw;
    expWe = pw || cw;
    expA  = pw ? r * 40 + c : 7;
    expD  = pw ? int'(b) : (s ? 8'h02 : 8'h07);
    t = tag != "" ? tag : (pw || (v && !cw)) ? reqOf(r, c) : cw ? "R3" : "R1";
    @(posedge clk); #2;
    check(t, memWe == expWe, "memWe", int'(memWe), int'(expWe));
    if (expWe && memWe) begin
      check(t, int'(memAddr) == expA, "memAddr", int'(memAddr), expA);
      check(t, int'(memData) == expD, "memData", int'(memData), expD);
    end
    mPend    = (s != mSearchQ) || (mPend && !cw);
    mSearchQ = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit s, e;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pktValid = 0; pktRow = 0; pktCol = 0; pktByte = 0;
    searching = 1; rowStoreEn = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", memWe == 1'b0, "reset memWe", int'(memWe), 0);
    @(negedge clk);
    rst_n = 1'b1;
    mPend = 1; mSearchQ = 1;

    // R3: reset queues a green control character
    step(0, 0, 0, 8'h00, 1, 0, "R3");
    step(0, 0, 0, 8'h00, 1, 0, "R1");
    // R2: status and control columns refused
    step(1, 0, 3, 8'h41, 1, 0, "R2");
    step(1, 0, 6, 8'h42, 1, 0, "R2");
    step(1, 0, 7, 8'h43, 1, 0, "R2");
    // R4: rolling header while searching, boundaries 8 and 31
    step(1, 0, 8, 8'h44, 1, 0, "R4");
    step(1, 0, 31, 8'h45, 1, 0, "R4");
    // R10: searching drops while packets keep arriving -> colour deferred
    step(1, 0, 35, 8'h46, 0, 0, "R5");
    step(1, 3, 0, 8'h47, 0, 0, "R10");
    step(1, 23, 39, 8'h48, 0, 0, "R10");
    step(0, 0, 0, 8'h00, 0, 0, "R10");   // white written now
    // R4 frozen, R5 time keeps rolling
    step(1, 0, 8, 8'h49, 0, 0, "R4");
    step(1, 0, 31, 8'h4a, 0, 0, "R4");
    step(1, 0, 32, 8'h4b, 0, 0, "R5");
    step(1, 0, 39, 8'h4c, 0, 0, "R5");
    // R6: row 24 gated by control bit
    step(1, 24, 5, 8'h4d, 0, 0, "R6");
    step(1, 24, 5, 8'h4e, 0, 1, "R6");
    // R7: body rows edges
    step(1, 1, 0, 8'h4f, 0, 1, "R7");
    step(1, 22, 20, 8'h50, 0, 1, "R7");
    // R8: row 25 split at column 10
    step(1, 25, 9, 8'h51, 0, 1, "R8");
    step(1, 25, 10, 8'h52, 0, 1, "R8");
    step(1, 25, 39, 8'h53, 0, 1, "R8");
    // R9: out of range
    step(1, 26, 0, 8'h54, 0, 1, "R9");
    step(1, 31, 5, 8'h55, 0, 1, "R9");
    step(1, 5, 40, 8'h56, 0, 1, "R9");
    // R10: two flips while busy collapse into one write with current value
    step(1, 2, 2, 8'h57, 1, 1, "R10");
    step(1, 2, 3, 8'h58, 0, 1, "R10");
    step(0, 0, 0, 8'h00, 0, 1, "R10");
    step(0, 0, 0, 8'h00, 0, 1, "R10");
    // R3: clean toggle to searching gives green
    step(0, 0, 0, 8'h00, 1, 1, "R1");
    step(0, 0, 0, 8'h00, 1, 1, "R3");

    s = 1; e = 0;
    for (int i = 0; i < 4000; i++) begin
      int r, c;
      bit v;
      if ($urandom_range(0, 15) == 0) s = !s;
      if ($urandom_range(0, 31) == 0) e = !e;
      v = $urandom_range(0, 3) != 0;
      r = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 31);
      c = $urandom_range(0, 47);
      step(v, r, c, 8'($urandom), s, e);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule